// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is an 8-bit timer that produces a square wave with a programmable period and duty. A free-running up counter advances on ticks from one of four count sources. Each time the counter reaches the duty value or the period value, the output flip-flop changes state. When the counter reaches the period value, it returns to zero on the following tick. As a result, one full wave cycle lasts period + 1 ticks, and the flip-flop toggles twice in each cycle. Each compare hit also raises its own one-cycle interrupt pulse.

Software programs the block through a simple write port that selects one of three targets: the duty value, the period value, or a control word. The control word holds the run bit, the count source, the duty double-buffer enable, the toggle enable, and a one-shot force command for the output level. The duty value must be smaller than the period value for a correct wave.

When double buffering is on, a new duty value waits in a buffer and takes effect only when the counter hits the period. This allows a low-duty wave to be updated without glitches.

Top module: `ppg_timer`

## Requirements
- R1: After synchronous reset, `wave_out`, `irq_duty` and `irq_period` are 0, the counter is 0, the run bit is clear, and the duty and period values are 0.
- R2: Control bits [2:1] select the count source: 0 = external input, 1 = `presc_tick[0]` (divide-by-1), 2 = `presc_tick[1]` (divide-by-4), 3 = `presc_tick[2]` (divide-by-16). Ticks on unselected sources have no effect on the counter.
- R3: While the run bit (control bit 0) is set, each tick of the selected source raises the counter by one. A tick taken when the counter equals the period value sets it to 0 instead, so one wave cycle is period + 1 ticks.
- R4: While the run bit is clear, the counter is held at 0, no ticks are taken, and `wave_out` keeps its level. Restarting therefore counts from 0.
- R5: When control bit 4 (toggle enable) is set, `wave_out` inverts at the clock edge where the counter takes the duty value or the period value. When bit 4 is clear, `wave_out` does not change on a hit.
- R6: `irq_duty` (or `irq_period`) is high for exactly the one cycle after the edge where the counter takes the duty (or period) value. Both pulses occur whether or not the toggle enable is set. Starting the counter at 0 is not a hit.
- R7: When control bit 3 (double buffer) is clear, a duty write (`wr_sel` = 0) takes effect at the edge of the write, including while the counter is running.
- R8: When control bit 3 is set, a duty write only loads the buffer. The buffer is copied into the active duty value at the edge where the counter takes the period value.
- R9: A control write (`wr_sel` = 2) with bits [6:5] = 1 forces `wave_out` to 0, and with bits [6:5] = 2 forces it to 1, at the edge of the write. Values 0 and 3 force nothing. A force takes priority over a toggle.
- R10: The external input passes through a two-stage synchronizer. Each rising edge produces exactly one tick, however long the input stays high, and the counter advances at the third clock edge after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 duty, 1 period, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| presc_tick | input | 3 | Prescaled count enables: divide-by-1, divide-by-4, divide-by-16 |
| ext_cnt | input | 1 | External count input (asynchronous) |
| wave_out | output | 1 | Square-wave output flip-flop |
| irq_duty | output | 1 | One-cycle pulse on a duty hit |
| irq_period | output | 1 | One-cycle pulse on a period hit |

## Verification
A write, a force, or a selected prescaler tick acts at the next clock edge. `wave_out` changes at that same edge, and the interrupt pulses are high during the cycle that follows it. The bench drives inputs and samples outputs on falling edges, so after the k-th counting edge it expects the counter to hold k. It places each expected toggle and pulse on exactly that falling edge and checks the cycle on either side as well. External-input results are due three edges after a rise, so the bench holds each level for six cycles and checks pulse counts instead of single cycles.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int CW = 8;

    typedef enum logic [1:0] {
        SRC_EXT   = 2'd0,
        SRC_DIV1  = 2'd1,
        SRC_DIV4  = 2'd2,
        SRC_DIV16 = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        WR_DUTY   = 2'd0,
        WR_PERIOD = 2'd1,
        WR_CTRL   = 2'd2,
        WR_NONE   = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        FRC_NONE = 2'd0,
        FRC_LOW  = 2'd1,
        FRC_HIGH = 2'd2,
        FRC_KEEP = 2'd3
    } frc_e;

    typedef struct packed {
        logic run;
        src_e src;
        logic dbuf;
        logic inv;
    } ctrl_t;

    typedef struct packed {
        logic hit_duty;
        logic hit_period;
    } match_t;

    function automatic ctrl_t decode_ctrl(input logic [CW-1:0] d);
        ctrl_t c;
        c.run  = d[0];
        c.src  = src_e'(d[2:1]);
        c.dbuf = d[3];
        c.inv  = d[4];
        return c;
    endfunction

    function automatic frc_e decode_force(input logic [CW-1:0] d);
        return frc_e'(d[6:5]);
    endfunction

    function automatic logic is_forcing(input frc_e f);
        return (f == FRC_LOW) || (f == FRC_HIGH);
    endfunction

endpackage

// File: rtl/ppg_tick_sel.sv
module ppg_tick_sel
    import ppg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  src_e       src,
    input  logic [2:0] presc_tick,
    input  logic       ext_in,
    output logic       tick
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic            ext_rise;
    logic            raw_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], ext_in};
        end
    end

    assign ext_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

    always_comb begin
        unique case (src)
            SRC_EXT:   raw_tick = ext_rise;
            SRC_DIV1:  raw_tick = presc_tick[0];
            SRC_DIV4:  raw_tick = presc_tick[1];
            SRC_DIV16: raw_tick = presc_tick[2];
            default:   raw_tick = 1'b0;
        endcase
    end

    assign tick = run & raw_tick;

    assert_ext_single_R10: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_EXT && tick) |=> !(src == SRC_EXT && tick));

endmodule

// File: rtl/ppg_counter.sv
module ppg_counter
    import ppg_pkg::*;
#(
    parameter int W = CW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         dbuf,
    input  logic         duty_we,
    input  logic         period_we,
    input  logic [W-1:0] wdata,
    output match_t       hit
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] period_q;
    logic [W-1:0] duty_q;
    logic [W-1:0] shadow_q;
    logic [W-1:0] cnt_nxt;
    logic         at_top;
    logic         commit;

    always_comb begin
        at_top         = (cnt_q == period_q);
        cnt_nxt        = at_top ? '0 : cnt_q + 1'b1;
        hit.hit_duty   = tick && (cnt_nxt == duty_q);
        hit.hit_period = tick && (cnt_nxt == period_q);
        commit         = hit.hit_period;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            period_q <= '0;
            duty_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (!run) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_nxt;
            end
            if (period_we) begin
                period_q <= wdata;
            end
            if (duty_we) begin
                shadow_q <= wdata;
            end
            if (duty_we && !dbuf) begin
                duty_q <= wdata;
            end else if (commit && dbuf) begin
                duty_q <= shadow_q;
            end
        end
    end

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !at_top) |=> cnt_q == W'($past(cnt_q) + 1'b1));

    assert_count_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (run && tick && at_top) |=> cnt_q == '0);

    assert_stop_clear_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);

    assert_direct_duty_R7: assert property (@(posedge clk) disable iff (rst)
        (duty_we && !dbuf) |=> duty_q == $past(wdata));

    assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dbuf && !commit) |=> $stable(duty_q));

endmodule

// File: rtl/ppg_outff.sv
module ppg_outff
    import ppg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   inv_en,
    input  match_t hit,
    input  frc_e   frc,
    output logic   q
);

    logic any_hit;

    assign any_hit = hit.hit_duty | hit.hit_period;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (frc == FRC_LOW) begin
            q <= 1'b0;
        end else if (frc == FRC_HIGH) begin
            q <= 1'b1;
        end else if (inv_en && any_hit) begin
            q <= ~q;
        end
    end

    assert_gate_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!inv_en && !is_forcing(frc)) |=> $stable(q));

    assert_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (inv_en && any_hit && !is_forcing(frc)) |=> q != $past(q));

    assert_force_high_R9: assert property (@(posedge clk) disable iff (rst)
        (frc == FRC_HIGH) |=> q);

    assert_force_low_R9: assert property (@(posedge clk) disable iff (rst)
        (frc == FRC_LOW) |=> !q);

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
    import ppg_pkg::*;
#(
    parameter int W           = CW,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   presc_tick,
    input  logic         ext_cnt,
    output logic         wave_out,
    output logic         irq_duty,
    output logic         irq_period
);

    ctrl_t  ctrl_q;
    frc_e   frc;
    match_t hit;
    logic   tick;
    logic   ctrl_we;
    logic   duty_we;
    logic   period_we;

    always_comb begin
        ctrl_we   = wr_en && (wsel_e'(wr_sel) == WR_CTRL);
        duty_we   = wr_en && (wsel_e'(wr_sel) == WR_DUTY);
        period_we = wr_en && (wsel_e'(wr_sel) == WR_PERIOD);
        frc       = ctrl_we ? decode_force(wr_data[CW-1:0]) : FRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            irq_duty   <= 1'b0;
            irq_period <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= decode_ctrl(wr_data[CW-1:0]);
            end
            irq_duty   <= hit.hit_duty;
            irq_period <= hit.hit_period;
        end
    end

    ppg_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk        (clk),
        .rst        (rst),
        .run        (ctrl_q.run),
        .src        (ctrl_q.src),
        .presc_tick (presc_tick),
        .ext_in     (ext_cnt),
        .tick       (tick)
    );

    ppg_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .tick      (tick),
        .dbuf      (ctrl_q.dbuf),
        .duty_we   (duty_we),
        .period_we (period_we),
        .wdata     (wr_data),
        .hit       (hit)
    );

    ppg_outff u_ff (
        .clk    (clk),
        .rst    (rst),
        .inv_en (ctrl_q.inv),
        .hit    (hit),
        .frc    (frc),
        .q      (wave_out)
    );

    assert_stop_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !is_forcing(frc)) |=> $stable(wave_out));

    assert_stop_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run |=> !irq_duty && !irq_period);

endmodule

// File: tb/sim_ppg_timer.sv
`timescale 1ns/1ps
module sim_ppg_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] presc = 3'b000;
    logic       ext_in = 1'b0;
    logic       wave, irq_d, irq_p;

    int checks = 0;
    int errors = 0;
    int nd = 0;
    int np = 0;

    always #4 clk = ~clk;

    ppg_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .presc_tick(presc), .ext_cnt(ext_in),
        .wave_out(wave), .irq_duty(irq_d), .irq_period(irq_p)
    );

    always @(posedge clk) begin
        if (irq_d === 1'b1) nd <= nd + 1;
        if (irq_p === 1'b1) np <= np + 1;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (ok !== 1'b1) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mk(input logic run, input logic [1:0] src,
                                      input logic dbuf, input logic inv, input logic [1:0] frc);
        return {1'b0, frc, inv, dbuf, src, run};
    endfunction

    // called on a falling edge; returns on the falling edge after the write edge
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic setup(input logic [7:0] duty, input logic [7:0] per);
        wr(2'd2, mk(0, 2'd1, 0, 0, 2'd1));
        wr(2'd0, duty);
        wr(2'd1, per);
    endtask

    task automatic t_reset;
        check(wave == 1'b0, "R1 wave_out", int'(wave), 0);
        check(irq_d == 1'b0 && irq_p == 1'b0, "R1 irqs", int'({irq_d, irq_p}), 0);
    endtask

    task automatic t_basic;
        logic ew = 1'b0;
        presc = 3'b001;
        setup(8'd2, 8'd5);
        wr(2'd2, mk(1, 2'd1, 0, 1, 2'd1));
        for (int k = 1; k <= 20; k++) begin
            logic ed, ep;
            @(negedge clk);
            ed = (k % 6 == 2);
            ep = (k % 6 == 5);
            if (ed || ep) ew = ~ew;
            check(irq_d == ed, "R6 irq_duty R3 count", int'(irq_d), int'(ed));
            check(irq_p == ep, "R6 irq_period R3 wrap", int'(irq_p), int'(ep));
            check(wave == ew, "R5 toggle", int'(wave), int'(ew));
        end
    endtask

    task automatic t_inv_off;
        int d0, p0;
        logic stuck = 1'b1;
        setup(8'd2, 8'd5);
        d0 = nd; p0 = np;
        wr(2'd2, mk(1, 2'd1, 0, 0, 2'd0));
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (wave !== 1'b0) stuck = 1'b0;
        end
        check(stuck, "R5 no toggle when disabled", int'(wave), 0);
        check(nd - d0 == 2, "R6 duty pulses without toggle", nd - d0, 2);
        check(np - p0 == 2, "R6 period pulses without toggle", np - p0, 2);
    endtask

    task automatic t_stop;
        int d0;
        logic held = 1'b1;
        setup(8'd2, 8'd5);
        wr(2'd2, mk(1, 2'd1, 0, 1, 2'd0));
        repeat (3) @(negedge clk);
        check(wave == 1'b1, "R4 pre-stop level", int'(wave), 1);
        wr(2'd2, mk(0, 2'd1, 0, 1, 2'd0));
        d0 = nd;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (wave !== 1'b1) held = 1'b0;
        end
        check(held, "R4 level held while stopped", int'(wave), 1);
        check(nd == d0, "R4 no pulses while stopped", nd - d0, 0);
        wr(2'd2, mk(1, 2'd1, 0, 1, 2'd0));
        @(negedge clk);
        check(irq_d == 1'b0, "R4 restart k1", int'(irq_d), 0);
        @(negedge clk);
        check(irq_d == 1'b1, "R4 restart from zero", int'(irq_d), 1);
    endtask

    task automatic t_force;
        wr(2'd2, mk(0, 2'd1, 0, 0, 2'd2));
        check(wave == 1'b1, "R9 force high", int'(wave), 1);
        wr(2'd2, mk(0, 2'd1, 0, 0, 2'd3));
        check(wave == 1'b1, "R9 code 3 no force", int'(wave), 1);
        wr(2'd2, mk(0, 2'd1, 0, 0, 2'd1));
        check(wave == 1'b0, "R9 force low", int'(wave), 0);
    endtask

    task automatic t_duty_update(input logic dbuf);
        int n = dbuf ? 20 : 12;
        setup(8'd2, 8'd9);
        wr(2'd2, mk(1, 2'd1, dbuf, 1, 2'd1));
        for (int k = 1; k <= n; k++) begin
            logic ed;
            @(negedge clk);
            if (dbuf) ed = (k == 2) || (k == 16);
            else      ed = (k == 2) || (k == 6);
            if (dbuf) check(irq_d == ed, "R8 buffered duty", int'(irq_d), int'(ed));
            else      check(irq_d == ed, "R7 direct duty", int'(irq_d), int'(ed));
            if (k == 4) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'd6;
            end else begin
                wr_en = 1'b0; wr_sel = 2'd3;
            end
        end
    endtask

    task automatic t_src(input logic [1:0] src, input logic [2:0] good, input logic [2:0] bad);
        int d0;
        setup(8'd3, 8'd9);
        presc = good;
        wr(2'd2, mk(1, src, 0, 0, 2'd0));
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check(irq_d == (k == 3), "R2 selected source counts", int'(irq_d), int'(k == 3));
        end
        wr(2'd2, mk(0, src, 0, 0, 2'd0));
        presc = bad;
        d0 = nd;
        wr(2'd2, mk(1, src, 0, 0, 2'd0));
        repeat (8) @(negedge clk);
        check(nd == d0, "R2 unselected source ignored", nd - d0, 0);
    endtask

    task automatic t_ext;
        int d0;
        setup(8'd3, 8'd200);
        presc = 3'b111;
        wr(2'd2, mk(1, 2'd0, 0, 0, 2'd0));
        d0 = nd;
        for (int e = 1; e <= 3; e++) begin
            ext_in = 1'b1;
            repeat (6) @(negedge clk);
            ext_in = 1'b0;
            repeat (6) @(negedge clk);
            if (e == 2) check(nd == d0, "R10 one tick per rise", nd - d0, 0);
        end
        check(nd == d0 + 1, "R10 third rise hits duty", nd - d0, 1);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_inv_off();
        t_stop();
        t_force();
        t_duty_update(1'b0);
        t_duty_update(1'b1);
        t_src(2'd1, 3'b001, 3'b110);
        t_src(2'd2, 3'b010, 3'b101);
        t_src(2'd3, 3'b100, 3'b011);
        t_ext();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule